// File: doc/BRIEF.md
# Commit-time upgrade queue for speculatively written shared lines

During speculative execution a cache line can be both speculatively written and held in a shared state. At commit such a line needs exclusive ownership before its speculative data can become dirty. This block keeps a short list of the addresses of those lines, so the commit sequence does not have to walk the whole cache to find them. The cache tracker posts an address when a line enters that combined condition. The block stores each distinct address once.

When commit begins, the block works through the list in the order addresses arrived. It presents one upgrade request at a time and waits for the acknowledgement carrying the same address. It then tells the cache to mark that line dirty. The cache applies the transition only if the line's speculative-write bit is still set. When the last acknowledgement returns, the block raises a one-cycle completion pulse, and the cache then flash-clears its speculative bits. If commit begins with an empty list, the pulse follows at once.

Running out of slots does not stall the processor. It raises a sticky overflow flag that makes the current epoch's speculation fail. A squash empties the list and clears the flag without sending any request.

Top module: `commit_upgrade_queue`

## Requirements
- R1: After reset, upg_req_valid, dirty_valid, flush_done and overflow are all 0 and the list is empty.
- R2: While idle, an insert of an address not already listed stores it in a free slot. Every stored address produces exactly one upgrade request during the following flush.
- R3: An insert whose address is already listed allocates nothing: it yields no extra request and, with the list full, raises no overflow.
- R4: Upgrade requests follow the order in which the addresses were first inserted. Request valid and address stay unchanged until upg_req_ready is sampled high.
- R5: At most one request is outstanding: upg_req_valid is low from the cycle after a request is accepted until the matching acknowledgement is taken.
- R6: An acknowledgement whose address differs from the outstanding request's address is ignored: no dirty pulse and no new request.
- R7: A matching acknowledgement produces, in the next cycle, a one-cycle dirty_valid pulse with dirty_addr equal to that address.
- R8: flush_done is a one-cycle pulse. It comes in the same cycle as the dirty pulse for the last listed address, or one cycle after commit_start when the list is empty.
- R9: An insert of a new address while all DEPTH slots are used stores nothing and sets overflow, which stays high until squash. While overflow is high, commit_start is ignored.
- R10: squash takes priority over everything. It empties the list and clears overflow, so from the next cycle no request is presented and a later commit completes at once.
- R11: Inserts are ignored while a flush is in progress or in a cycle where commit_start is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert strobe from the cache tracker |
| ins_addr | input | AW | Line address to record |
| squash | input | 1 | Speculation failed: discard the list |
| commit_start | input | 1 | Begin the commit flush |
| upg_req_valid | output | 1 | Upgrade request presented |
| upg_req_addr | output | AW | Address of the presented request |
| upg_req_ready | input | 1 | Interconnect accepts the request |
| upg_ack_valid | input | 1 | Upgrade acknowledgement strobe |
| upg_ack_addr | input | AW | Address carried by the acknowledgement |
| dirty_valid | output | 1 | Mark-dirty pulse to the cache |
| dirty_addr | output | AW | Line to mark dirty |
| flush_done | output | 1 | Flush complete pulse |
| overflow | output | 1 | Sticky slot exhaustion, forces speculation failure |

## Verification
The bench builds the block with DEPTH=4 and AW=4. At this size it can sweep every fill level from empty to full, plus one insert past full. Overflow, a duplicate insert into a full list and the empty-commit completion are all reached within a few cycles. The 16-value address space lets each expected request order, mismatching acknowledgement and dirty address be computed arithmetically. Varying ready delays per pattern exercise request hold.

// File: rtl/cuq_pkg.sv
package cuq_pkg;
  typedef enum logic [1:0] {
    CQ_IDLE  = 2'd0,
    CQ_ISSUE = 2'd1,
    CQ_WAIT  = 2'd2
  } cq_state_e;
endpackage

// File: rtl/cuq_prio.sv
// Lowest-index-first selector over a request vector.
module cuq_prio #(
  parameter int unsigned N = 12,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cuq_slots.sv
// Address slot storage with valid bits and associative lookup.
module cuq_slots #(
  parameter int unsigned N  = 12,
  parameter int unsigned AW = 26,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [AW-1:0]        wr_addr,
  input  logic                 rm_en,
  input  logic [IW-1:0]        rm_idx,
  input  logic [AW-1:0]        look_addr,
  output logic [N-1:0]         vld,
  output logic [N-1:0][AW-1:0] slot_addr,
  output logic                 hit
);
  logic [N-1:0] vld_d;
  logic [N-1:0] hit_vec;

  always_comb begin
    vld_d = vld;
    if (clr) begin
      vld_d = '0;
    end else begin
      if (rm_en)  vld_d[rm_idx] = 1'b0;
      if (wr_en)  vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= vld_d;
  end

  for (genvar g = 0; g < int'(N); g++) begin : g_slot
    logic [AW-1:0] a_q;
    logic          we;
    assign we = wr_en && !clr && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (we) a_q <= wr_addr;
    end
    assign slot_addr[g] = a_q;
    assign hit_vec[g]   = vld[g] && (a_q == look_addr);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/commit_upgrade_queue.sv
module commit_upgrade_queue #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned AW    = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic          squash,
  input  logic          commit_start,
  output logic          upg_req_valid,
  output logic [AW-1:0] upg_req_addr,
  input  logic          upg_req_ready,
  input  logic          upg_ack_valid,
  input  logic [AW-1:0] upg_ack_addr,
  output logic          dirty_valid,
  output logic [AW-1:0] dirty_addr,
  output logic          flush_done,
  output logic          overflow
);
  import cuq_pkg::*;
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  cq_state_e state_q, state_d;
  logic [IW-1:0] cur_q, cur_d;
  logic ovf_q, ovf_d;
  logic done_q, done_d;
  logic dv_q, dv_d;
  logic [AW-1:0] da_q;

  logic [DEPTH-1:0]          vld;
  logic [DEPTH-1:0][AW-1:0]  slot_addr;
  logic                      hit;
  logic                      free_any, occ_any;
  logic [IW-1:0]             free_idx, occ_idx;
  logic                      wr_en, rm_en, clr;
  logic                      accept_ins, ack_match, rest_any;
  logic [DEPTH-1:0]          vld_rest;

  cuq_slots #(.N(DEPTH), .AW(AW)) u_slots (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en), .wr_idx(free_idx), .wr_addr(ins_addr),
    .rm_en(rm_en), .rm_idx(cur_q), .look_addr(ins_addr),
    .vld(vld), .slot_addr(slot_addr), .hit(hit)
  );

  cuq_prio #(.N(DEPTH)) u_free (.vec(~vld), .any(free_any), .idx(free_idx));
  cuq_prio #(.N(DEPTH)) u_occ  (.vec(vld),  .any(occ_any),  .idx(occ_idx));

  assign accept_ins = (state_q == CQ_IDLE) && ins_valid && !squash &&
                      !commit_start && !ovf_q && !hit;
  assign wr_en      = accept_ins && free_any;
  assign ack_match  = (state_q == CQ_WAIT) && upg_ack_valid &&
                      (upg_ack_addr == slot_addr[cur_q]);

  always_comb begin
    vld_rest        = vld;
    vld_rest[cur_q] = 1'b0;
  end
  assign rest_any = |vld_rest;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    ovf_d   = ovf_q;
    done_d  = 1'b0;
    dv_d    = 1'b0;
    rm_en   = 1'b0;
    clr     = 1'b0;
    if (squash) begin
      state_d = CQ_IDLE;
      ovf_d   = 1'b0;
      clr     = 1'b1;
    end else begin
      unique case (state_q)
        CQ_IDLE: begin
          if (accept_ins && !free_any) ovf_d = 1'b1;
          if (commit_start && !ovf_q) begin
            if (occ_any) state_d = CQ_ISSUE;
            else         done_d  = 1'b1;
          end
        end
        CQ_ISSUE: begin
          if (upg_req_ready) begin
            cur_d   = occ_idx;
            state_d = CQ_WAIT;
          end
        end
        CQ_WAIT: begin
          if (ack_match) begin
            rm_en = 1'b1;
            dv_d  = 1'b1;
            if (rest_any) state_d = CQ_ISSUE;
            else begin
              state_d = CQ_IDLE;
              done_d  = 1'b1;
            end
          end
        end
        default: state_d = CQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CQ_IDLE;
      cur_q   <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
      dv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
      dv_q    <= dv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dv_d) da_q <= slot_addr[cur_q];
  end

  assign upg_req_valid = (state_q == CQ_ISSUE);
  assign upg_req_addr  = slot_addr[occ_idx];
  assign dirty_valid   = dv_q;
  assign dirty_addr    = da_q;
  assign flush_done    = done_q;
  assign overflow      = ovf_q;
endmodule

// File: rtl/cuq_checker.sv
module cuq_checker #(
  parameter int unsigned AW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          squash,
  input logic          upg_req_valid,
  input logic [AW-1:0] upg_req_addr,
  input logic          upg_req_ready,
  input logic          upg_ack_valid,
  input logic          dirty_valid,
  input logic          flush_done,
  input logic          overflow
);
  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upg_req_valid && upg_req_ready) |=> !upg_req_valid);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upg_req_valid && !upg_req_ready && !squash) |=> (upg_req_valid && $stable(upg_req_addr)));

  p_dirty_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |-> ($past(upg_ack_valid) && !$past(squash)));

  p_dirty_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |=> !dirty_valid);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  p_no_req_in_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !upg_req_valid);

  p_squash_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (!upg_req_valid && !overflow && !flush_done && !dirty_valid));
endmodule

bind commit_upgrade_queue cuq_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .squash(squash),
  .upg_req_valid(upg_req_valid), .upg_req_addr(upg_req_addr),
  .upg_req_ready(upg_req_ready), .upg_ack_valid(upg_ack_valid),
  .dirty_valid(dirty_valid), .flush_done(flush_done), .overflow(overflow)
);

// File: tb/sim_commit_upgrade_queue.sv
`timescale 1ns/1ps
module sim_commit_upgrade_queue;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned AW    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_valid, squash, commit_start, upg_req_ready, upg_ack_valid;
  logic [AW-1:0] ins_addr, upg_ack_addr;
  logic upg_req_valid, dirty_valid, flush_done, overflow;
  logic [AW-1:0] upg_req_addr, dirty_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [AW-1:0] exp_q [DEPTH];

  always #5 clk = ~clk;

  commit_upgrade_queue #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .squash(squash), .commit_start(commit_start),
    .upg_req_valid(upg_req_valid), .upg_req_addr(upg_req_addr),
    .upg_req_ready(upg_req_ready), .upg_ack_valid(upg_ack_valid),
    .upg_ack_addr(upg_ack_addr), .dirty_valid(dirty_valid),
    .dirty_addr(dirty_addr), .flush_done(flush_done), .overflow(overflow)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic ins(input logic [AW-1:0] a);
    ins_valid = 1'b1; ins_addr = a;
    tick();
    ins_valid = 1'b0;
  endtask

  task automatic commit_pulse();
    commit_start = 1'b1;
    tick();
    commit_start = 1'b0;
  endtask

  task automatic drain(input int n, input int p);
    for (int i = 0; i < n; i++) begin
      chk(upg_req_valid == 1'b1, "R2 request present", int'(upg_req_valid), 1);
      chk(upg_req_addr == exp_q[i], "R4 request order", int'(upg_req_addr), int'(exp_q[i]));
      for (int d = 0; d < (i + p) % 3; d++) begin
        upg_req_ready = 1'b0;
        tick();
        chk(upg_req_valid && upg_req_addr == exp_q[i], "R4 hold", int'(upg_req_addr), int'(exp_q[i]));
      end
      upg_req_ready = 1'b1;
      tick();
      upg_req_ready = 1'b0;
      chk(upg_req_valid == 1'b0, "R5 single outstanding", int'(upg_req_valid), 0);
      upg_ack_valid = 1'b1; upg_ack_addr = exp_q[i] ^ 4'h8;
      tick();
      upg_ack_valid = 1'b0;
      chk(dirty_valid == 1'b0, "R6 mismatch no dirty", int'(dirty_valid), 0);
      chk(upg_req_valid == 1'b0, "R6 mismatch no request", int'(upg_req_valid), 0);
      upg_ack_valid = 1'b1; upg_ack_addr = exp_q[i];
      tick();
      upg_ack_valid = 1'b0;
      chk(dirty_valid && dirty_addr == exp_q[i], "R7 dirty pulse", int'(dirty_addr), int'(exp_q[i]));
      chk(flush_done == (i == n - 1), "R8 done timing", int'(flush_done), int'(i == n - 1));
    end
    tick();
    chk(!flush_done && !dirty_valid, "R8 done one cycle", int'(flush_done), 0);
    chk(upg_req_valid == 1'b0, "R2 each address once", int'(upg_req_valid), 0);
  endtask

  task automatic empty_commit(input string req);
    commit_pulse();
    chk(flush_done == 1'b1, req, int'(flush_done), 1);
    chk(upg_req_valid == 1'b0, req, int'(upg_req_valid), 0);
    tick();
    chk(flush_done == 1'b0, "R8 empty pulse one cycle", int'(flush_done), 0);
  endtask

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_addr = '0; squash = 1'b0;
    commit_start = 1'b0; upg_req_ready = 1'b0; upg_ack_valid = 1'b0; upg_ack_addr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(!upg_req_valid && !dirty_valid && !flush_done && !overflow, "R1 reset outputs",
        int'({upg_req_valid, dirty_valid, flush_done, overflow}), 0);
    empty_commit("R1 reset empty");

    // R2 R3 R4 R5 R6 R7 R8: every fill level, several address patterns
    for (int p = 0; p < 3; p++) begin
      for (int n = 0; n <= int'(DEPTH); n++) begin
        for (int i = 0; i < n; i++) begin
          exp_q[i] = AW'(p * 5 + i * 3 + 1);
          ins(exp_q[i]);
        end
        if (n > 0) ins(exp_q[0]);   // R3 duplicate
        chk(overflow == 1'b0, "R3 duplicate no overflow", int'(overflow), 0);
        if (n == 0) empty_commit("R8 empty commit");
        else begin
          commit_pulse();
          chk(flush_done == 1'b0, "R8 not early", int'(flush_done), 0);
          drain(n, p);
        end
      end
    end

    // R9 overflow
    for (int i = 0; i < int'(DEPTH); i++) ins(AW'(i * 2));
    chk(overflow == 1'b0, "R9 full no overflow", int'(overflow), 0);
    ins(AW'(2));
    chk(overflow == 1'b0, "R3 dup while full", int'(overflow), 0);
    ins(AW'(15));
    chk(overflow == 1'b1, "R9 overflow set", int'(overflow), 1);
    tick();
    chk(overflow == 1'b1, "R9 overflow sticky", int'(overflow), 1);
    commit_pulse();
    chk(!upg_req_valid && !flush_done, "R9 commit ignored", int'(upg_req_valid), 0);
    tick();
    chk(!upg_req_valid && !flush_done, "R9 commit ignored later", int'(flush_done), 0);
    squash = 1'b1; tick(); squash = 1'b0;
    chk(overflow == 1'b0, "R10 squash clears overflow", int'(overflow), 1'b0);
    empty_commit("R10 list empty after squash");

    // R10 squash during flush
    ins(4'h3); ins(4'h6); ins(4'h9);
    commit_pulse();
    chk(upg_req_valid == 1'b1, "R10 flush started", int'(upg_req_valid), 1);
    squash = 1'b1; tick(); squash = 1'b0;
    chk(!upg_req_valid && !dirty_valid, "R10 no request after squash", int'(upg_req_valid), 0);
    tick();
    chk(!upg_req_valid && !flush_done, "R10 stays quiet", int'(upg_req_valid), 0);
    empty_commit("R10 commit after squash");

    // R11 inserts ignored during flush and with commit_start
    exp_q[0] = 4'hA; exp_q[1] = 4'h5;
    ins(exp_q[0]); ins(exp_q[1]);
    commit_start = 1'b1; ins_valid = 1'b1; ins_addr = 4'hC;
    tick();
    commit_start = 1'b0; ins_valid = 1'b0;
    ins(4'hE);   // while request pending
    drain(2, 1);
    empty_commit("R11 inserts not stored");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule